// File: doc/BRIEF.md
# Instruction Fetch Stage with Redirect and Squash

This block owns the program counter of a five-stage in-order pipeline. Every cycle it presents the current PC as a word address to an instruction memory that answers combinationally. It then captures the returned word, together with the address of the following word, into the register between fetch and decode. With no other input active, the PC moves forward by one word per cycle. This means conditional skips are implicitly predicted not taken, and fetch never waits on them.

The decode stage resolves jumps, calls, returns and taken skips one cycle after fetch. It reports each one as a redirect with a target address. On a redirect the PC loads the target. The word fetched behind the control-transfer instruction is discarded: a multiplexer feeds a no-op constant into the buffer instead of that word, and no asynchronous clear is used. A stall request from hazard logic freezes both the PC and the buffer by withholding their write enables. A redirect in the same cycle as a stall overrides the stall.

Top module: `fetch_stage`

## Requirements
- R1: While the synchronous active-high reset `rst` is high at a rising edge, the next state is PC = 0, `ifid_instr` = NOOP and `ifid_link` = 0.
- R2: With `rst`, `stall` and `redirect_valid` all low, the PC becomes PC+1. The buffer loads the memory word read at the old PC. No wait is inserted for any instruction, which is a not-taken prediction.
- R3: With `redirect_valid` high and `rst` low, the next PC equals `redirect_target`.
- R4: With `redirect_valid` high and `rst` low, the buffer loads `ifid_instr` = NOOP and `ifid_link` = 0, squashing the word fetched in that cycle.
- R5: With `stall` high and `rst` and `redirect_valid` low, the PC, `ifid_instr` and `ifid_link` keep their values.
- R6: When `redirect_valid` and `stall` are both high, the redirect and squash of R3 and R4 take effect and the stall is ignored.
- R7: Sequential advance from PC = 2^ADDR_W-1 wraps to PC = 0.
- R8: On a sequential advance, `ifid_link` becomes the old PC plus one (modulo 2^ADDR_W), which equals the new `imem_addr`.
- R9: Reset takes priority over a redirect or stall presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Hold PC and fetch/decode buffer |
| redirect_valid | input | 1 | Decode reports a control transfer this cycle |
| redirect_target | input | ADDR_W | Word address to fetch next on redirect |
| imem_addr | output | ADDR_W | Word address to instruction memory (the PC) |
| imem_rdata | input | INSTR_W | Word returned by instruction memory |
| ifid_instr | output | INSTR_W | Buffered instruction for decode |
| ifid_link | output | ADDR_W | Buffered address of the following word |

## Verification
A redirect and a stall can fall in the same cycle, and so can a reset with either of them. The bench drives these pairs on purpose, and it also runs a long random phase in which each input is independently likely to be active. A behavioural model applies the priority of reset over redirect over stall. It predicts the PC and both buffer fields for every clock, and compares them at the falling edge after each rising edge. The case of redirect with stall is judged on whether the target appears on the address output and a no-op appears in the buffer, rather than the PC holding.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

  // Next-state selection shared by the PC register and the fetch buffer.
  typedef enum logic [1:0] {
    NXT_ADVANCE = 2'd0,
    NXT_REDIRECT = 2'd1,
    NXT_FREEZE = 2'd2,
    NXT_CLEAR = 2'd3
  } nxt_sel_e;

endpackage

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import fetch_pkg::*;
(
  input  logic     rst,
  input  logic     stall,
  input  logic     redirect_valid,
  output nxt_sel_e sel
);

  // Priority: reset, then redirect, then stall, then advance.
  always_comb begin
    if (rst)                 sel = NXT_CLEAR;
    else if (redirect_valid) sel = NXT_REDIRECT;
    else if (stall)          sel = NXT_FREEZE;
    else                     sel = NXT_ADVANCE;
  end

endmodule

// File: rtl/fetch_pc_reg.sv
module fetch_pc_reg
  import fetch_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  nxt_sel_e          sel,
  input  logic [ADDR_W-1:0] target,
  input  logic [ADDR_W-1:0] pc_inc,
  output logic [ADDR_W-1:0] pc
);

  localparam logic [ADDR_W-1:0] PC_TOP = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] pc_d;

  always_comb begin
    unique case (sel)
      NXT_CLEAR:    pc_d = '0;
      NXT_REDIRECT: pc_d = target;
      NXT_FREEZE:   pc_d = pc;
      default:      pc_d = pc_inc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_d;
  end

  AST_PC_CLEAR: assert property (@(posedge clk) rst |=> pc == '0); // R1
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    sel == NXT_ADVANCE |=> pc == ADDR_W'($past(pc) + 1'b1)); // R2
  AST_PC_TARGET: assert property (@(posedge clk) disable iff (rst)
    sel == NXT_REDIRECT |=> pc == $past(target)); // R3
  AST_PC_FREEZE: assert property (@(posedge clk) disable iff (rst)
    sel == NXT_FREEZE |=> $stable(pc)); // R5
  AST_PC_WRAP: assert property (@(posedge clk) disable iff (rst)
    (sel == NXT_ADVANCE && pc == PC_TOP) |=> pc == '0); // R7

endmodule

// File: rtl/fetch_ifid_buf.sv
module fetch_ifid_buf
  import fetch_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int INSTR_W = 32,
  parameter logic [INSTR_W-1:0] NOOP = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  nxt_sel_e           sel,
  input  logic [INSTR_W-1:0] fetch_word,
  input  logic [ADDR_W-1:0]  fetch_link,
  output logic [INSTR_W-1:0] instr_q,
  output logic [ADDR_W-1:0]  link_q
);

  logic               load_en;
  logic               squash;
  logic [INSTR_W-1:0] instr_d;
  logic [ADDR_W-1:0]  link_d;

  assign load_en = (sel != NXT_FREEZE);
  assign squash  = (sel == NXT_REDIRECT) || (sel == NXT_CLEAR);

  // No-op mux on the buffer input instead of a register clear.
  assign instr_d = squash ? NOOP : fetch_word;
  assign link_d  = squash ? '0   : fetch_link;

  always_ff @(posedge clk) begin
    if (rst) begin
      instr_q <= NOOP;
      link_q  <= '0;
    end else if (load_en) begin
      instr_q <= instr_d;
      link_q  <= link_d;
    end
  end

  AST_BUF_CLEAR: assert property (@(posedge clk)
    rst |=> (instr_q == NOOP && link_q == '0)); // R1
  AST_BUF_LOAD: assert property (@(posedge clk) disable iff (rst)
    sel == NXT_ADVANCE |=> instr_q == $past(fetch_word)); // R2
  AST_BUF_SQUASH: assert property (@(posedge clk) disable iff (rst)
    sel == NXT_REDIRECT |=> (instr_q == NOOP && link_q == '0)); // R4
  AST_BUF_FREEZE: assert property (@(posedge clk) disable iff (rst)
    sel == NXT_FREEZE |=> ($stable(instr_q) && $stable(link_q))); // R5

endmodule

// File: rtl/fetch_stage.sv
module fetch_stage
  import fetch_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int INSTR_W = 32,
  parameter logic [INSTR_W-1:0] NOOP = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               stall,
  input  logic               redirect_valid,
  input  logic [ADDR_W-1:0]  redirect_target,
  output logic [ADDR_W-1:0]  imem_addr,
  input  logic [INSTR_W-1:0] imem_rdata,
  output logic [INSTR_W-1:0] ifid_instr,
  output logic [ADDR_W-1:0]  ifid_link
);

  nxt_sel_e          sel;
  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] pc_inc;

  assign pc_inc    = ADDR_W'(pc + 1'b1);
  assign imem_addr = pc;

  fetch_ctrl u_ctrl (
    .rst            (rst),
    .stall          (stall),
    .redirect_valid (redirect_valid),
    .sel            (sel)
  );

  fetch_pc_reg #(.ADDR_W(ADDR_W)) u_pc (
    .clk    (clk),
    .rst    (rst),
    .sel    (sel),
    .target (redirect_target),
    .pc_inc (pc_inc),
    .pc     (pc)
  );

  fetch_ifid_buf #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .NOOP(NOOP)) u_buf (
    .clk        (clk),
    .rst        (rst),
    .sel        (sel),
    .fetch_word (imem_rdata),
    .fetch_link (pc_inc),
    .instr_q    (ifid_instr),
    .link_q     (ifid_link)
  );

  AST_LINK_MATCH: assert property (@(posedge clk) disable iff (rst)
    (!stall && !redirect_valid) |=> ifid_link == imem_addr); // R8
  AST_REDIR_OVER_STALL: assert property (@(posedge clk) disable iff (rst)
    (stall && redirect_valid) |=> (imem_addr == $past(redirect_target) && ifid_instr == NOOP)); // R6
  AST_RESET_FIRST: assert property (@(posedge clk)
    (rst && redirect_valid) |=> imem_addr == '0); // R9

endmodule

// File: tb/fetch_stage_test.sv
module fetch_stage_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int IW = 32;
  localparam logic [IW-1:0] NOP_WORD = 32'h0000_0000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          stall = 1'b0;
  logic          redirect_valid = 1'b0;
  logic [AW-1:0] redirect_target = '0;
  logic [AW-1:0] imem_addr;
  logic [IW-1:0] imem_rdata;
  logic [IW-1:0] ifid_instr;
  logic [AW-1:0] ifid_link;

  int vectors = 0;
  int errors = 0;
  bit finished = 0;

  // Expected state
  logic [AW-1:0] e_pc = '0;
  logic [IW-1:0] e_instr = NOP_WORD;
  logic [AW-1:0] e_link = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [IW-1:0] mem_word(input logic [AW-1:0] a);
    return 32'h1357_0000 ^ ({16'h0, a} * 32'h9E37_79B1) ^ 32'h0000_0001;
  endfunction

  assign imem_rdata = mem_word(imem_addr);

  fetch_stage #(.ADDR_W(AW), .INSTR_W(IW), .NOOP(NOP_WORD)) uut (
    .clk             (clk),
    .rst             (rst),
    .stall           (stall),
    .redirect_valid  (redirect_valid),
    .redirect_target (redirect_target),
    .imem_addr       (imem_addr),
    .imem_rdata      (imem_rdata),
    .ifid_instr      (ifid_instr),
    .ifid_link       (ifid_link)
  );

  task automatic check(input string tag, input string what,
                       input logic [IW-1:0] act, input logic [IW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Apply one cycle of inputs (after a falling edge), update the model,
  // then compare at the next falling edge.
  task automatic step(input bit r, input bit s, input bit rv,
                      input logic [AW-1:0] tgt, input string tag);
    rst = r; stall = s; redirect_valid = rv; redirect_target = tgt;
    if (r) begin
      e_pc = '0; e_instr = NOP_WORD; e_link = '0;
    end else if (rv) begin
      e_pc = tgt; e_instr = NOP_WORD; e_link = '0;
    end else if (!s) begin
      e_instr = mem_word(e_pc);
      e_link = AW'(e_pc + 1);
      e_pc = AW'(e_pc + 1);
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, "imem_addr", IW'(imem_addr), IW'(e_pc));
    check(tag, "ifid_instr", ifid_instr, e_instr);
    check(tag, "ifid_link", IW'(ifid_link), IW'(e_link));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(1, 0, 0, '0, "R1");
    step(1, 0, 0, '0, "R1");
    for (int i = 0; i < 6; i++) step(0, 0, 0, '0, "R2_R8");
    for (int i = 0; i < 3; i++) step(0, 1, 0, '0, "R5");
    step(0, 0, 0, '0, "R2");
    step(0, 0, 1, 16'h0100, "R3_R4");
    for (int i = 0; i < 3; i++) step(0, 0, 0, '0, "R2_R8");
    step(0, 1, 1, 16'h0230, "R6");
    step(0, 1, 0, '0, "R5");
    step(0, 0, 1, 16'h0040, "R3_R4");
    step(0, 0, 1, 16'h0050, "R3_R4");
    step(0, 0, 1, 16'hFFFE, "R3");
    for (int i = 0; i < 4; i++) step(0, 0, 0, '0, "R7");
    step(1, 0, 1, 16'h0777, "R9");
    step(1, 1, 0, '0, "R9");
    step(0, 0, 0, '0, "R2");
    for (int i = 0; i < 400; i++) begin
      bit rs = ($urandom_range(0, 39) == 0);
      bit st = ($urandom_range(0, 3) == 0);
      bit rd = ($urandom_range(0, 4) == 0);
      step(rs, st, rd, AW'($urandom), rd && st ? "R6" : (rd ? "R4" : (st ? "R5" : "R2")));
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule